// File: doc/BRIEF.md
# PCM Transmit Serial Port

The block sends one 13-bit two's-complement voice sample per 8 kHz frame on a serial line that can be released to high impedance. An external bit clock of 256 kHz to 4.8 MHz times everything: data changes on its rising edges and the frame sync is sampled on its falling edges. The serial data pin and its output enable come out separately, so a pad cell or a shared bus driver can be attached outside the block.

Each frame sync pulse is classified by how many falling edges see it high. One edge makes a short pulse; two or more make a long pulse. The class of the pulse that has just ended governs the next frame: it sets when the first bit is driven and when the line is released. A mode input selects a 16-bit word in which the sign is repeated into the three leading bits. A power-up input forces the line off, and after power returns the first two frame syncs are let pass with nothing sent.

Top module: `pcm_tx_port`

## Requirements
- R1: While rst_ni is low and after its release, before any frame has been sent, sdata_oe_o is 0 and sdata_o is 0.
- R2: A sync pulse seen high on exactly one bit-clock falling edge is short; one seen high on two or more consecutive falling edges is long. Each frame is handled by the class of the previous pulse, and the class is short after reset or power-up, so a pulse of a new class is itself still handled by the old class.
- R3: In a frame handled as short, the sign bit (sample bit 12) goes out on the rising edge after the first falling edge that sees the sync high, and the next bits follow, most significant first, one per rising edge.
- R4: In a frame handled as long, the sign bit goes out on the first rising edge that sees the sync high after a rising edge that saw it low, and the next bits follow one per rising edge.
- R5: In a frame handled as short, sdata_oe_o is 1 from the first bit and returns to 0 on the falling edge inside the last bit period.
- R6: In a frame handled as long, sdata_oe_o is 1 while the sync is high and while the word is being sent, and goes to 0 at the later of the sync going low and the falling edge inside the last bit period.
- R7: When wide_i is 1 at the first bit, the word is 16 bits long and its first four bits all equal sample bit 12; when wide_i is 0, the word is the 13 sample bits.
- R8: The sample is taken from sample_i on the rising edge that drives the first bit; later changes of sample_i do not alter the word in flight.
- R9: Once the word is done, and outside any frame, sdata_oe_o is 0 (except while a long sync is still high) and sdata_o is 0 until the next frame's first bit.
- R10: While pwr_up_i is 0 nothing is sent and sdata_oe_o is 0; after pwr_up_i returns to 1, the first two sync pulses are let pass with sdata_oe_o held at 0, and the third frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock; data on rising edges, sync sampled on falling edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | 8 kHz frame sync, short or long pulse |
| sample_i | input | 13 | Two's-complement sample to send |
| wide_i | input | 1 | 1 selects the 16-bit sign-extended word |
| pwr_up_i | input | 1 | 1 = powered up, 0 = powered down |
| sdata_o | output | 1 | Serial data, most significant bit first; 0 when no bit is sent |
| sdata_oe_o | output | 1 | 1 when the serial line is driven |

## Verification
Each data bit is due on a rising edge and is read five time units after it, well before the following falling edge. Each release through the last-bit falling edge is due on that falling edge and is read one time unit after it, before the bench moves the sync and the sample two time units after the same edge. The bench keeps its own model of the pulse class, the power-up count and the sign extension, and it predicts, for every bit-clock cycle of every frame, the start cycle (0 for long handling, 1 for short) and both enable readings.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SAMPLE_W    = 13;
  localparam int WIDE_W      = 16;
  localparam int MUTE_FRAMES = 2;
endpackage

// File: rtl/pcm_tx_sync_detect.sv
module pcm_tx_sync_detect #(
  parameter int MUTE_FRAMES = pcm_tx_pkg::MUTE_FRAMES
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic pwr_up_i,
  output logic first_o,
  output logic long_o,
  output logic armed_o
);
  localparam int MW = $clog2(MUTE_FRAMES + 1);
  localparam logic [MW-1:0] MUTE_MAX = MW'(MUTE_FRAMES);

  logic          fs_q;
  logic [1:0]    run_q;
  logic          first_q;
  logic          long_q;
  logic [MW-1:0] mute_q;

  // falling-edge side: pulse length, class of last pulse, power-up mute
  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q    <= 1'b0;
      run_q   <= '0;
      first_q <= 1'b0;
      long_q  <= 1'b0;
      mute_q  <= '0;
    end else if (!pwr_up_i) begin
      fs_q    <= fsync_i;
      run_q   <= '0;
      first_q <= 1'b0;
      long_q  <= 1'b0;
      mute_q  <= '0;
    end else begin
      fs_q    <= fsync_i;
      first_q <= fsync_i & ~fs_q;
      if (fsync_i) begin
        if (run_q != 2'd2) run_q <= run_q + 2'd1;
      end else begin
        run_q <= '0;
      end
      if (!fsync_i && fs_q) begin
        long_q <= (run_q == 2'd2);
        if (mute_q != MUTE_MAX) mute_q <= mute_q + MW'(1);
      end
    end
  end

  assign first_o = first_q;
  assign long_o  = long_q;
  assign armed_o = (mute_q == MUTE_MAX);
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int SAMPLE_W = pcm_tx_pkg::SAMPLE_W,
  parameter int WIDE_W   = pcm_tx_pkg::WIDE_W
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic                fsync_i,
  input  logic                pwr_up_i,
  input  logic                first_i,
  input  logic                long_i,
  input  logic                armed_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                wide_i,
  output logic                tx_on_o,
  output logic                at_lsb_o,
  output logic                hold_o,
  output logic                bit_o
);
  localparam int EXT = WIDE_W - SAMPLE_W;
  localparam int CW  = $clog2(WIDE_W);
  localparam logic [CW-1:0] LAST_N = CW'(SAMPLE_W - 1);
  localparam logic [CW-1:0] LAST_W = CW'(WIDE_W - 1);

  logic [WIDE_W-1:0] wide_word, narrow_word;
  logic [WIDE_W-1:0] word_q;
  logic [CW-1:0]     cnt_q, last_q;
  logic              fs_q, tx_on_q, hold_q, start;

  if (EXT > 0) begin : g_ext
    assign wide_word   = {{EXT{sample_i[SAMPLE_W-1]}}, sample_i};
    assign narrow_word = {sample_i, {EXT{1'b0}}};
  end else begin : g_noext
    assign wide_word   = sample_i;
    assign narrow_word = sample_i;
  end

  // long frames start at the sync edge, short ones after the sampled pulse
  assign start = armed_i & pwr_up_i & (long_i ? (fsync_i & ~fs_q) : first_i);

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q    <= 1'b0;
      tx_on_q <= 1'b0;
      hold_q  <= 1'b0;
      word_q  <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
    end else begin
      fs_q <= fsync_i;
      if (!pwr_up_i) begin
        tx_on_q <= 1'b0;
        hold_q  <= 1'b0;
      end else if (start) begin
        tx_on_q <= 1'b1;
        hold_q  <= long_i;
        word_q  <= wide_i ? wide_word : narrow_word;
        cnt_q   <= '0;
        last_q  <= wide_i ? LAST_W : LAST_N;
      end else begin
        hold_q <= hold_q & fsync_i;
        if (tx_on_q) begin
          if (cnt_q == last_q) begin
            tx_on_q <= 1'b0;
          end else begin
            cnt_q  <= cnt_q + CW'(1);
            word_q <= {word_q[WIDE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign tx_on_o  = tx_on_q;
  assign at_lsb_o = tx_on_q & (cnt_q == last_q);
  assign hold_o   = hold_q;
  assign bit_o    = tx_on_q & word_q[WIDE_W-1];
endmodule

// File: rtl/pcm_tx_oe_ctrl.sv
module pcm_tx_oe_ctrl (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic tx_on_i,
  input  logic at_lsb_i,
  input  logic hold_i,
  input  logic bit_i,
  output logic sdata_o,
  output logic sdata_oe_o
);
  logic lsb_half_q;

  // set on the falling edge inside the last bit
  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) lsb_half_q <= 1'b0;
    else         lsb_half_q <= at_lsb_i;
  end

  assign sdata_oe_o = (tx_on_i & ~lsb_half_q) | (hold_i & fsync_i);
  assign sdata_o    = bit_i;
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int SAMPLE_W    = pcm_tx_pkg::SAMPLE_W,
  parameter int WIDE_W      = pcm_tx_pkg::WIDE_W,
  parameter int MUTE_FRAMES = pcm_tx_pkg::MUTE_FRAMES
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic                fsync_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                wide_i,
  input  logic                pwr_up_i,
  output logic                sdata_o,
  output logic                sdata_oe_o
);
  logic first, long_frame, armed;
  logic tx_on, at_lsb, hold, tx_bit;

  pcm_tx_sync_detect #(.MUTE_FRAMES(MUTE_FRAMES)) i_sync (
    .bclk_i   (bclk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .pwr_up_i (pwr_up_i),
    .first_o  (first),
    .long_o   (long_frame),
    .armed_o  (armed)
  );

  pcm_tx_shifter #(.SAMPLE_W(SAMPLE_W), .WIDE_W(WIDE_W)) i_shift (
    .bclk_i   (bclk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .pwr_up_i (pwr_up_i),
    .first_i  (first),
    .long_i   (long_frame),
    .armed_i  (armed),
    .sample_i (sample_i),
    .wide_i   (wide_i),
    .tx_on_o  (tx_on),
    .at_lsb_o (at_lsb),
    .hold_o   (hold),
    .bit_o    (tx_bit)
  );

  pcm_tx_oe_ctrl i_oe (
    .bclk_i     (bclk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .tx_on_i    (tx_on),
    .at_lsb_i   (at_lsb),
    .hold_i     (hold),
    .bit_i      (tx_bit),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
  );
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic bclk_i,
  input logic rst_ni,
  input logic fsync_i,
  input logic pwr_up_i,
  input logic sdata_oe_o,
  input logic tx_on,
  input logic armed
);
  logic [4:0] bits_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (tx_on) bits_q <= bits_q + 5'd1;
    else            bits_q <= '0;
  end

  p_word_len_r7: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    $fell(tx_on) |-> (bits_q == 5'(pcm_tx_pkg::SAMPLE_W) || bits_q == 5'(pcm_tx_pkg::WIDE_W)));

  p_start_armed_r10: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    $rose(tx_on) |-> $past(armed && pwr_up_i));

  p_pwr_off_quiet_r10: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !pwr_up_i |=> !sdata_oe_o);

  p_drive_needs_sync_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (sdata_oe_o && !tx_on) |-> fsync_i);
endmodule

bind pcm_tx_port pcm_tx_port_chk i_chk (
  .bclk_i     (bclk_i),
  .rst_ni     (rst_ni),
  .fsync_i    (fsync_i),
  .pwr_up_i   (pwr_up_i),
  .sdata_oe_o (sdata_oe_o),
  .tx_on      (tx_on),
  .armed      (armed)
);

// File: tb/test_pcm_tx_port.sv
module test_pcm_tx_port;
  localparam int CLK_PERIOD = 20;
  localparam int FRAME      = 32;
  localparam int NVEC       = 11;

  // {len[3:0], wide, chg, sample[12:0]}
  localparam logic [18:0] VECS [NVEC] = '{
    {4'd1,  1'b0, 1'b0, 13'h0AAA},
    {4'd1,  1'b0, 1'b0, 13'h1F0F},
    {4'd1,  1'b0, 1'b0, 13'h1555},
    {4'd1,  1'b1, 1'b0, 13'h1234},
    {4'd3,  1'b0, 1'b0, 13'h0F0F},
    {4'd3,  1'b0, 1'b1, 13'h0321},
    {4'd15, 1'b1, 1'b0, 13'h1ABC},
    {4'd2,  1'b0, 1'b0, 13'h0001},
    {4'd1,  1'b0, 1'b0, 13'h1000},
    {4'd1,  1'b1, 1'b1, 13'h0FFF},
    {4'd1,  1'b1, 1'b0, 13'h0000}
  };

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [12:0] sample = '0;
  logic        wide = 1'b0;
  logic        pwr_up = 1'b1;
  logic        sdata, sdata_oe;

  int n_chk = 0, n_fail = 0, ends = 0;
  bit h_long = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  pcm_tx_port i_pcm_tx_port (
    .bclk_i(bclk), .rst_ni(rst_n), .fsync_i(fsync), .sample_i(sample),
    .wide_i(wide), .pwr_up_i(pwr_up), .sdata_o(sdata), .sdata_oe_o(sdata_oe)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // entry and exit: two time units after a falling edge
  task automatic run_frame(int len, bit wd, bit chg, logic [12:0] smp, bit pwr);
    int   w, s;
    bit   armed, in_word, e_oe, mis;
    logic [15:0] word;
    string tg_d, tg_o;
    w     = wd ? 16 : 13;
    s     = h_long ? 0 : 1;
    armed = pwr && (ends >= 2);
    mis   = ((len >= 2) != h_long);
    word  = wd ? {{3{smp[12]}}, smp} : {3'b000, smp};
    for (int c = 0; c < FRAME; c++) begin
      pwr_up = pwr;
      fsync  = (c < len);
      if (c == 0) begin sample = smp; wide = wd; end
      if (chg && c == 3) sample = ~smp;
      in_word = armed && c >= s && c <= s + w - 1;
      if (!armed)             tg_d = "R10";
      else if (chg && in_word) tg_d = "R8";
      else if (mis)           tg_d = "R2";
      else if (!in_word)      tg_d = "R9";
      else if (wd)            tg_d = "R7";
      else                    tg_d = h_long ? "R4" : "R3";
      if (!armed)                     tg_o = "R10";
      else if (h_long && c < len)     tg_o = "R6";
      else if (c > s + w - 1 || c < s) tg_o = "R9";
      else                            tg_o = h_long ? "R6" : "R5";
      @(posedge bclk); #5;
      e_oe = in_word || (armed && h_long && c < len);
      check_eq(tg_o, $sformatf("oe high phase cycle %0d", c), int'(sdata_oe), int'(e_oe));
      check_eq(tg_d, $sformatf("data cycle %0d", c), int'(sdata),
               in_word ? int'(word[w-1-(c-s)]) : 0);
      @(negedge bclk); #1;
      e_oe = (armed && c >= s && c < s + w - 1) || (armed && h_long && c < len);
      check_eq(tg_o, $sformatf("oe low phase cycle %0d", c), int'(sdata_oe), int'(e_oe));
      #1;
    end
    if (pwr) begin
      if (ends < 2) ends++;
      h_long = (len >= 2);
    end else begin
      ends   = 0;
      h_long = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge bclk);
    #1;
    check_eq("R1", "oe in reset", int'(sdata_oe), 0);
    check_eq("R1", "data in reset", int'(sdata), 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge bclk);
    #1;
    check_eq("R1", "oe after reset", int'(sdata_oe), 0);
    check_eq("R1", "data after reset", int'(sdata), 0);
    #1;
    for (int i = 0; i < NVEC; i++)
      run_frame(int'(VECS[i][18:15]), VECS[i][14], VECS[i][13], VECS[i][12:0], 1'b1);
    // power-down, then two silent frames and a sent one (R10)
    run_frame(2, 1'b0, 1'b0, 13'h1111, 1'b0);
    run_frame(2, 1'b0, 1'b0, 13'h0AAA, 1'b1);
    run_frame(2, 1'b0, 1'b0, 13'h1555, 1'b1);
    run_frame(2, 1'b0, 1'b0, 13'h0CCC, 1'b1);
    run_frame(1, 1'b1, 1'b0, 13'h1F01, 1'b1);
    run_frame(1, 1'b0, 1'b0, 13'h0133, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule